// File: doc/BRIEF.md
# Cacheable Read Line-Fill Controller

This block sequences the bus cycle for each access that a processor data cache hands it. It decides whether the access runs as a four-beat burst that fills a cache line or as a single transfer. It drives a burst-request output and a page-cache-disable output from the page attributes as soon as the address strobe goes out. This happens before the system has said whether the region may be cached.

Whether a cycle is cacheable is decided by both sides. The block raises its burst request, and on the first ready acknowledge the system answers with its cache-enable input. A burst line fill results only when both agree. When a fill runs, the new line's MESI state is derived from the page writethrough attribute and a system writeback/writethrough input, both captured on that first acknowledge. Read hits need no bus cycle and return the line's existing state. Writes leave as single writethrough transfers.

Top module: `lf_fill_ctrl`

## Requirements
- R1: `bus_cache_req` and `bus_pcd` are never high in the same cycle.
- R2: `bus_pcd` equals the access's page cache-disable attribute. `bus_cache_req` is high only for a read miss whose page is not cache-disabled and whose no-cache hint is clear. Both are valid in the `bus_start` cycle and hold until the cycle completes. `sys_ken` and `sys_wb` have no effect on either.
- R3: A write runs as one single transfer with `bus_write` high, `bus_cache_req` low and `bus_be` equal to the request's byte mask (1 to 8 bytes). It reports type 2, one beat, no allocation and the prior state.
- R4: A read miss with `bus_cache_req` low, or with `sys_ken` low on the first ready, completes after one beat. It reports type 1, no allocation and state I.
- R5: A read miss with `bus_cache_req` high and `sys_ken` high on the first ready continues to 4 beats and reports type 3 with `done_alloc` high.
- R6: MESI encoding is I=0, S=1, E=2, M=3. A filled line is E when `sys_wb` was high and the page writethrough attribute is clear. Otherwise it is S. The state is reported only in the `done` cycle that follows the last ready.
- R7: `sys_ken` and `sys_wb` are sampled only on the first ready of a cycle. Changes to them on later beats are ignored.
- R8: A read hit starts no bus cycle. `done` comes in the cycle after acceptance, with type 0, zero beats, no allocation and `done_state` equal to the prior state.
- R9: `req_ready` is high only while no access is in flight. `done` and `bus_start` are single-cycle pulses.
- R10: After reset, `req_ready` is high and every bus and result output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| req_valid | input | 1 | Access request presented |
| req_ready | output | 1 | Controller idle, request accepted this cycle |
| req_write | input | 1 | Access is a write |
| req_hit | input | 1 | Access hit in the cache |
| req_prior | input | 2 | Prior MESI state of the line |
| req_pcd | input | 1 | Page cache-disable attribute |
| req_pwt | input | 1 | Page writethrough attribute |
| req_nocache | input | 1 | Hint that suppresses the burst request |
| req_be | input | BEAT_BYTES | Byte mask for writes |
| bus_start | output | 1 | Address strobe, one cycle |
| bus_cache_req | output | 1 | Burst request |
| bus_pcd | output | 1 | Page cache-disable output |
| bus_write | output | 1 | Bus cycle direction |
| bus_be | output | BEAT_BYTES | Byte enables of the bus cycle |
| bus_ready | input | 1 | Ready acknowledge per beat |
| sys_ken | input | 1 | System cache-enable |
| sys_wb | input | 1 | System writeback (1) / writethrough (0) |
| done | output | 1 | Access complete, one cycle |
| done_type | output | 2 | 0 none, 1 single read, 2 single write, 3 line fill |
| done_beats | output | clog2(LINE_BEATS+1) | Beats transferred |
| done_alloc | output | 1 | Write the filled line |
| done_state | output | 2 | Line MESI state |

## Verification
The hardest case to reach is a cache-enable or writeback input that changes after the first beat of a fill. A design that samples these inputs on every beat, or on the last one, still looks correct whenever the inputs stay steady. The bench's bus responder can invert `sys_ken` and `sys_wb` as soon as it has seen the first ready. It also inserts wait states, so the later beats land on cycles where the inverted values are present. A full sweep of read misses over cache-disable, no-cache hint, cache-enable, writethrough and writeback then ties each cycle type and line state to its inputs.

// File: rtl/lf_pkg.sv
package lf_pkg;

  typedef enum logic [1:0] {
    CYC_NONE      = 2'd0,
    CYC_RD_SINGLE = 2'd1,
    CYC_WR_SINGLE = 2'd2,
    CYC_FILL      = 2'd3
  } cyc_e;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_DONE = 2'd3
  } phase_e;

  typedef struct packed {
    logic  write;
    logic  cache_req;
    logic  pcd;
    logic  pwt;
    mesi_e prior;
  } acc_t;

endpackage

// File: rtl/lf_attr_dec.sv
module lf_attr_dec (
  input  logic write,
  input  logic hit,
  input  logic pcd,
  input  logic nocache,
  output logic needs_bus,
  output logic cache_req,
  output logic pcd_out
);

  // Any write goes out as a writethrough transfer; only read hits stay local.
  assign needs_bus = write | ~hit;
  // Burst request depends on the page attribute and hint only, never on the system answer.
  assign cache_req = ~write & ~hit & ~pcd & ~nocache;
  assign pcd_out   = pcd;

endmodule

// File: rtl/lf_beat_ctr.sv
module lf_beat_ctr #(
  parameter int LINE_BEATS = 4,
  localparam int CNT_W     = $clog2(LINE_BEATS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic             last,
  output logic             first
);

  logic [CNT_W-1:0] count_d;
  logic             count_en;

  always_comb begin
    count_en = clr | inc;
    count_d  = count;
    if (clr) begin
      count_d = '0;
    end else if (inc) begin
      count_d = count + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (count_en) begin
      count <= count_d;
    end
  end

  assign last  = (count == CNT_W'(LINE_BEATS - 1));
  assign first = (count == '0);

endmodule

// File: rtl/lf_mesi_sel.sv
module lf_mesi_sel
  import lf_pkg::*;
(
  input  logic  pwt,
  input  logic  wb,
  output mesi_e fill_state
);

  always_comb begin
    if (wb && !pwt) begin
      fill_state = ST_E;
    end else begin
      fill_state = ST_S;
    end
  end

endmodule

// File: rtl/lf_fill_ctrl.sv
module lf_fill_ctrl
  import lf_pkg::*;
#(
  parameter int LINE_BEATS = 4,
  parameter int BEAT_BYTES = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req_valid,
  output logic                               req_ready,
  input  logic                               req_write,
  input  logic                               req_hit,
  input  logic [1:0]                         req_prior,
  input  logic                               req_pcd,
  input  logic                               req_pwt,
  input  logic                               req_nocache,
  input  logic [BEAT_BYTES-1:0]              req_be,
  output logic                               bus_start,
  output logic                               bus_cache_req,
  output logic                               bus_pcd,
  output logic                               bus_write,
  output logic [BEAT_BYTES-1:0]              bus_be,
  input  logic                               bus_ready,
  input  logic                               sys_ken,
  input  logic                               sys_wb,
  output logic                               done,
  output logic [1:0]                         done_type,
  output logic [$clog2(LINE_BEATS+1)-1:0]    done_beats,
  output logic                               done_alloc,
  output logic [1:0]                         done_state
);

  localparam int CNT_W = $clog2(LINE_BEATS + 1);

  phase_e                phase_q, phase_d;
  acc_t                  acc_q, acc_d;
  logic [BEAT_BYTES-1:0] be_q, be_d;
  logic                  acc_en;

  logic                  burst_q, burst_d;
  logic                  wb_q, wb_d;
  logic                  smp_en;

  cyc_e                  res_type_q, res_type_d;
  logic [CNT_W-1:0]      res_beats_q, res_beats_d;
  logic                  res_alloc_q, res_alloc_d;
  mesi_e                 res_state_q, res_state_d;
  logic                  res_en;

  logic                  dec_needs_bus, dec_cache_req, dec_pcd;
  logic                  ctr_clr, ctr_inc;
  logic [CNT_W-1:0]      beat_cnt;
  logic                  beat_last, beat_first;
  logic                  burst_now, wb_now, fin;
  mesi_e                 fill_state;
  logic                  in_bus;

  lf_attr_dec u_dec (
    .write     (req_write),
    .hit       (req_hit),
    .pcd       (req_pcd),
    .nocache   (req_nocache),
    .needs_bus (dec_needs_bus),
    .cache_req (dec_cache_req),
    .pcd_out   (dec_pcd)
  );

  lf_beat_ctr #(.LINE_BEATS(LINE_BEATS)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctr_clr),
    .inc   (ctr_inc),
    .count (beat_cnt),
    .last  (beat_last),
    .first (beat_first)
  );

  // On the first beat the live system inputs decide; later beats use the captured copy.
  assign burst_now = beat_first ? (acc_q.cache_req & sys_ken) : burst_q;
  assign wb_now    = beat_first ? sys_wb : wb_q;
  assign fin       = ~burst_now | beat_last;

  lf_mesi_sel u_mesi (
    .pwt        (acc_q.pwt),
    .wb         (wb_now),
    .fill_state (fill_state)
  );

  // Next-state logic
  always_comb begin
    phase_d     = phase_q;
    acc_d       = acc_q;
    be_d        = be_q;
    acc_en      = 1'b0;
    burst_d     = burst_q;
    wb_d        = wb_q;
    smp_en      = 1'b0;
    res_type_d  = res_type_q;
    res_beats_d = res_beats_q;
    res_alloc_d = res_alloc_q;
    res_state_d = res_state_q;
    res_en      = 1'b0;
    ctr_clr     = 1'b0;
    ctr_inc     = 1'b0;

    unique case (phase_q)
      PH_IDLE: begin
        ctr_clr = 1'b1;
        if (req_valid) begin
          acc_en          = 1'b1;
          acc_d.write     = req_write;
          acc_d.cache_req = dec_cache_req;
          acc_d.pcd       = dec_pcd;
          acc_d.pwt       = req_pwt;
          acc_d.prior     = mesi_e'(req_prior);
          be_d            = req_write ? req_be : '1;
          if (dec_needs_bus) begin
            phase_d = PH_ADDR;
          end else begin
            phase_d     = PH_DONE;
            res_en      = 1'b1;
            res_type_d  = CYC_NONE;
            res_beats_d = '0;
            res_alloc_d = 1'b0;
            res_state_d = mesi_e'(req_prior);
          end
        end
      end

      PH_ADDR: begin
        phase_d = PH_DATA;
      end

      PH_DATA: begin
        if (bus_ready) begin
          ctr_inc = 1'b1;
          smp_en  = 1'b1;
          burst_d = burst_now;
          wb_d    = wb_now;
          if (fin) begin
            phase_d     = PH_DONE;
            res_en      = 1'b1;
            res_beats_d = beat_cnt + CNT_W'(1);
            res_alloc_d = burst_now;
            if (acc_q.write) begin
              res_type_d  = CYC_WR_SINGLE;
              res_state_d = acc_q.prior;
            end else if (burst_now) begin
              res_type_d  = CYC_FILL;
              res_state_d = fill_state;
            end else begin
              res_type_d  = CYC_RD_SINGLE;
              res_state_d = ST_I;
            end
          end
        end
      end

      PH_DONE: begin
        phase_d = PH_IDLE;
      end

      default: begin
        phase_d = PH_IDLE;
      end
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      be_q  <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
      be_q  <= be_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_q <= 1'b0;
      wb_q    <= 1'b0;
    end else if (smp_en) begin
      burst_q <= burst_d;
      wb_q    <= wb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_type_q  <= CYC_NONE;
      res_beats_q <= '0;
      res_alloc_q <= 1'b0;
      res_state_q <= ST_I;
    end else if (res_en) begin
      res_type_q  <= res_type_d;
      res_beats_q <= res_beats_d;
      res_alloc_q <= res_alloc_d;
      res_state_q <= res_state_d;
    end
  end

  // Outputs
  assign in_bus        = (phase_q == PH_ADDR) | (phase_q == PH_DATA);
  assign req_ready     = (phase_q == PH_IDLE);
  assign bus_start     = (phase_q == PH_ADDR);
  assign bus_cache_req = in_bus & acc_q.cache_req;
  assign bus_pcd       = in_bus & acc_q.pcd;
  assign bus_write     = in_bus & acc_q.write;
  assign bus_be        = in_bus ? be_q : '0;

  assign done          = (phase_q == PH_DONE);
  assign done_type     = done ? res_type_q : 2'd0;
  assign done_beats    = done ? res_beats_q : '0;
  assign done_alloc    = done & res_alloc_q;
  assign done_state    = done ? res_state_q : 2'd0;

endmodule

// File: rtl/lf_fill_ctrl_chk.sv
module lf_fill_ctrl_chk #(
  parameter int LINE_BEATS = 4,
  parameter int BEAT_BYTES = 8
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            req_valid,
  input logic                            req_ready,
  input logic                            req_write,
  input logic                            req_hit,
  input logic                            bus_start,
  input logic                            bus_cache_req,
  input logic                            bus_pcd,
  input logic                            bus_write,
  input logic [BEAT_BYTES-1:0]           bus_be,
  input logic                            done,
  input logic [1:0]                      done_type,
  input logic [$clog2(LINE_BEATS+1)-1:0] done_beats,
  input logic                            done_alloc,
  input logic [1:0]                      done_state
);

  logic inflight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight <= 1'b0;
    end else if (bus_start) begin
      inflight <= 1'b1;
    end else if (done) begin
      inflight <= 1'b0;
    end
  end

  a_r1_no_burst_with_pcd: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cache_req |-> !bus_pcd);

  a_r2_attr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight && !done) |-> ($stable(bus_pcd) && $stable(bus_cache_req) && $stable(bus_be)));

  a_r3_write_no_burst: assert property (@(posedge clk) disable iff (!rst_n)
    bus_write |-> (!bus_cache_req && bus_be != '0));

  a_r3_write_single: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_type == 2'd2) |-> (done_beats == 1 && !done_alloc));

  a_r4_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_type == 2'd1) |-> (done_beats == 1 && !done_alloc && done_state == 2'd0));

  a_r5_fill_len: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_type == 2'd3) |-> (done_beats == LINE_BEATS && done_alloc));

  a_r6_alloc_state: assert property (@(posedge clk) disable iff (!rst_n)
    done_alloc |-> (done && (done_state == 2'd1 || done_state == 2'd2)));

  a_r8_hit_local: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_hit && !req_write) |=> (done && !bus_start && done_type == 2'd0));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> !bus_start);

  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight || done) |-> !req_ready);

endmodule

bind lf_fill_ctrl lf_fill_ctrl_chk #(
  .LINE_BEATS(LINE_BEATS),
  .BEAT_BYTES(BEAT_BYTES)
) chk_i (.*);

// File: tb/lf_fill_ctrl_tb_top.sv
`timescale 1ns/1ps
module lf_fill_ctrl_tb_top;

  localparam int LB  = 4;
  localparam int BB  = 8;
  localparam int CW  = $clog2(LB + 1);

  logic          clk;
  logic          rst_n;
  logic          req_valid, req_ready, req_write, req_hit;
  logic [1:0]    req_prior;
  logic          req_pcd, req_pwt, req_nocache;
  logic [BB-1:0] req_be;
  logic          bus_start, bus_cache_req, bus_pcd, bus_write;
  logic [BB-1:0] bus_be;
  logic          bus_ready, sys_ken, sys_wb;
  logic          done;
  logic [1:0]    done_type;
  logic [CW-1:0] done_beats;
  logic          done_alloc;
  logic [1:0]    done_state;

  lf_fill_ctrl #(.LINE_BEATS(LB), .BEAT_BYTES(BB)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_hit(req_hit), .req_prior(req_prior), .req_pcd(req_pcd),
    .req_pwt(req_pwt), .req_nocache(req_nocache), .req_be(req_be),
    .bus_start(bus_start), .bus_cache_req(bus_cache_req), .bus_pcd(bus_pcd),
    .bus_write(bus_write), .bus_be(bus_be), .bus_ready(bus_ready),
    .sys_ken(sys_ken), .sys_wb(sys_wb),
    .done(done), .done_type(done_type), .done_beats(done_beats),
    .done_alloc(done_alloc), .done_state(done_state)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    int    typ;
    int    beats;
    int    alloc;
    int    st;
    string tag;
  } res_exp_t;

  typedef struct {
    int    creq;
    int    pcd;
    int    wr;
    int    be;
    string tag;
  } bus_exp_t;

  res_exp_t res_q[$];
  bus_exp_t bus_q[$];

  int checks = 0;
  int errors = 0;
  int pending = 0;
  int beats_seen = 0;
  int stall_ctr = 0;
  bit busy = 0;
  bit flip_en = 0;
  bit flipped = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Monitor and bus responder
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_ready) beats_seen++;
      if (flip_en && !flipped && beats_seen == 1) begin
        sys_ken = ~sys_ken;
        sys_wb  = ~sys_wb;
        flipped = 1'b1;
      end
      if (bus_start) begin
        chk(!(bus_cache_req && bus_pcd), "R1", "burst with pcd", 1, 0);
        chk(req_ready == 1'b0, "R9", "ready during cycle", int'(req_ready), 0);
        if (bus_q.size() == 0) begin
          chk(1'b0, "R8", "unexpected bus_start", 1, 0);
        end else begin
          bus_exp_t b;
          b = bus_q.pop_front();
          chk(int'(bus_cache_req) == b.creq, b.tag, "bus_cache_req", int'(bus_cache_req), b.creq);
          chk(int'(bus_pcd) == b.pcd, b.tag, "bus_pcd", int'(bus_pcd), b.pcd);
          chk(int'(bus_write) == b.wr, b.tag, "bus_write", int'(bus_write), b.wr);
          chk(int'(bus_be) == b.be, b.tag, "bus_be", int'(bus_be), b.be);
        end
        busy       = 1'b1;
        beats_seen = 0;
        bus_ready  = 1'b0;
      end else if (done) begin
        if (res_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected done", 1, 0);
        end else begin
          res_exp_t e;
          e = res_q.pop_front();
          chk(int'(done_type) == e.typ, e.tag, "done_type", int'(done_type), e.typ);
          chk(int'(done_beats) == e.beats, e.tag, "done_beats", int'(done_beats), e.beats);
          chk(beats_seen == e.beats, e.tag, "ready beats used", beats_seen, e.beats);
          chk(int'(done_alloc) == e.alloc, e.tag, "done_alloc", int'(done_alloc), e.alloc);
          chk(int'(done_state) == e.st, e.tag, "done_state", int'(done_state), e.st);
        end
        busy       = 1'b0;
        bus_ready  = 1'b0;
        beats_seen = 0;
        pending--;
      end else if (busy) begin
        stall_ctr++;
        bus_ready = (stall_ctr % 3) != 0;
      end
    end
  end

  task automatic access(input bit wr, input bit hit, input int prior,
                        input bit pcd, input bit pwt, input bit noc,
                        input int be, input bit ken, input bit wb,
                        input bit flip);
    res_exp_t e;
    bus_exp_t b;
    bit creq, cacheable;
    creq      = !wr && !hit && !pcd && !noc;
    cacheable = creq && ken;
    if (wr) begin
      e.typ = 2; e.beats = 1; e.alloc = 0; e.st = prior; e.tag = "R3";
    end else if (hit) begin
      e.typ = 0; e.beats = 0; e.alloc = 0; e.st = prior; e.tag = "R8";
    end else if (cacheable) begin
      e.typ = 3; e.beats = LB; e.alloc = 1;
      e.st = (wb && !pwt) ? 2 : 1;
      e.tag = flip ? "R7" : "R5/R6";
    end else begin
      e.typ = 1; e.beats = 1; e.alloc = 0; e.st = 0; e.tag = "R4";
    end
    res_q.push_back(e);
    if (wr || !hit) begin
      b.creq = int'(creq); b.pcd = int'(pcd); b.wr = int'(wr);
      b.be = wr ? be : 255; b.tag = wr ? "R3" : "R2";
      bus_q.push_back(b);
    end
    pending++;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    sys_ken     = ken;
    sys_wb      = wb;
    flip_en     = flip;
    flipped     = 1'b0;
    req_valid   = 1'b1;
    req_write   = wr;
    req_hit     = hit;
    req_prior   = 2'(prior);
    req_pcd     = pcd;
    req_pwt     = pwt;
    req_nocache = noc;
    req_be      = 8'(be);
    @(negedge clk);
    req_valid   = 1'b0;
    while (pending != 0) @(negedge clk);
    flip_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_hit = 1'b0;
    req_prior = 2'd0; req_pcd = 1'b0; req_pwt = 1'b0; req_nocache = 1'b0;
    req_be = '0; bus_ready = 1'b0; sys_ken = 1'b0; sys_wb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(req_ready == 1'b1, "R10", "req_ready", int'(req_ready), 1);
    chk(done == 1'b0, "R10", "done", int'(done), 0);
    chk(bus_start == 1'b0, "R10", "bus_start", int'(bus_start), 0);
    chk(bus_cache_req == 1'b0 && bus_pcd == 1'b0, "R10", "bus attrs",
        int'({bus_cache_req, bus_pcd}), 0);
    chk(done_state == 2'd0 && done_alloc == 1'b0, "R10", "result",
        int'({done_alloc, done_state}), 0);

    // R2 R4 R5 R6: every read-miss combination of the attribute and system inputs
    for (int i = 0; i < 32; i++) begin
      access(1'b0, 1'b0, 0, i[4], i[3], i[2], 0, i[1], i[0], 1'b0);
    end

    // R3 writes with several byte masks
    access(1'b1, 1'b0, 1, 1'b0, 1'b0, 1'b0, 8'h01, 1'b1, 1'b1, 1'b0);
    access(1'b1, 1'b0, 1, 1'b1, 1'b1, 1'b0, 8'hff, 1'b1, 1'b1, 1'b0);
    access(1'b1, 1'b1, 1, 1'b0, 1'b0, 1'b0, 8'h3c, 1'b1, 1'b0, 1'b0);

    // R8 read hits keep the prior state
    for (int p = 0; p < 4; p++) begin
      access(1'b0, 1'b1, p, 1'b0, 1'b0, 1'b0, 0, 1'b1, 1'b1, 1'b0);
    end

    // R7 system inputs flipped after the first beat
    access(1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b0, 0, 1'b1, 1'b1, 1'b1);
    access(1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b0, 0, 1'b1, 1'b0, 1'b1);
    access(1'b0, 1'b0, 0, 1'b0, 1'b1, 1'b0, 0, 1'b1, 1'b0, 1'b1);

    repeat (5) @(negedge clk);
    chk(res_q.size() == 0 && bus_q.size() == 0, "R9", "leftover items",
        res_q.size() + bus_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule